// File: doc/BRIEF.md
# Fine-Code Calibration Table Builder

This block turns the raw bin number from a delay-line interpolator into a calibrated time within one clock period. Raising the calibration control starts a new pass. Every later hit whose arrival is unrelated to the sampling clock adds one to the counter of its fine bin. The pass stops once a programmed number of hits N has been gathered. The block then visits the bins one after another. For each bin, a serial divider turns the bin's share of the hits into a width in picoseconds. Each bin is then given the time at its own midpoint: the widths of all lower bins added up, plus half its own width.

While the control is low, every valid raw code returns one calibrated time on the next cycle. If no table has been finished since the last pass began, the code is instead scaled linearly across the period. The first result produced after a pass ends carries a suspect flag, because it may still hold a calibration hit.

Top module: `tdc_bin_calibrator`

## Requirements
- R1: While reset is held, and on the first cycle after it, `cal_valid`, `cal_suspect` and `table_done` are low.
- R2: While `table_done` is low, a hit with `cal_mode` low produces `cal_valid` high on the next cycle with `cal_time` = floor(code × PERIOD_PS / 2^FINE_W).
- R3: `cal_valid` never rises for a hit presented while `cal_mode` is high.
- R4: A rising edge of `cal_mode` clears every bin count. Hits are counted only in later cycles while `cal_mode` stays high, and only the first N of them. Any hit beyond N leaves the table unchanged.
- R5: The width of bin i is floor(count_i × PERIOD_PS / N).
- R6: The calibrated time of bin i is the sum of the widths of bins 0..i-1 plus floor(width_i / 2).
- R7: `table_done` goes low on the cycle after `cal_mode` rises. It stays low until all 2^FINE_W bins have been computed. It rises within 2^FINE_W × (CNT_W + TIME_W + 3) + 10 cycles of the N-th hit.
- R8: While `table_done` is high, a hit with `cal_mode` low returns the calibrated time of its bin on the next cycle.
- R9: `cal_suspect` is high together with `cal_valid` only for the first apply-mode hit presented on or after the cycle in which `cal_mode` falls.
- R10: A `total_hits` value of 0, sampled when `cal_mode` rises, is treated as N = 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cal_mode | input | 1 | High: gather histogram; rising edge starts a new pass |
| total_hits | input | CNT_W | Hit total N, sampled on the rising edge of `cal_mode` |
| raw_valid | input | 1 | Raw fine code present this cycle |
| raw_code | input | FINE_W | Raw fine bin number |
| cal_valid | output | 1 | Calibrated result present |
| cal_time | output | TIME_W | Calibrated time in picoseconds within the period |
| cal_suspect | output | 1 | Result may be contaminated by the calibration pass just ended |
| table_done | output | 1 | Calibration table complete and in use |

## Verification
The hardest situations to reach are those where a pass is disturbed. One is a pass that is abandoned halfway by dropping the control and then restarted. The other is a hit arriving after the N-th has already closed the histogram. Both can only be seen through the table values produced afterwards. The stimulus drops `cal_mode` mid-pass, sends apply hits to observe the suspect flag and the linear fallback, and raises `cal_mode` again. It then sweeps every code to show that the abandoned bin reads zero width. A pass with N = 0 and an extra hit in another bin exercises the clamp and the cut-off, and the hand-computable 2500 / 5000 ps results confirm both.

// File: rtl/tcal_pkg.sv
`timescale 1ns/1ps
package tcal_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_HIST,
    ST_LOAD,
    ST_WAIT,
    ST_DONE
  } tcal_state_e;

  // Uncalibrated fallback: code spread evenly over the period.
  function automatic int unsigned lin_time(input int unsigned code,
                                           input int unsigned period,
                                           input int unsigned shift);
    return (code * period) >> shift;
  endfunction

  // Midpoint of a bin that starts at acc and is w wide.
  function automatic int unsigned mid_time(input int unsigned acc,
                                           input int unsigned w);
    return acc + (w >> 1);
  endfunction

endpackage

// File: rtl/tcal_divider.sv
`timescale 1ns/1ps
module tcal_divider #(
  parameter int NUM_W = 25,
  parameter int DEN_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             start,
  input  logic [NUM_W-1:0] num,
  input  logic [DEN_W-1:0] den,
  output logic             busy,
  output logic             done,
  output logic [NUM_W-1:0] quo
);
  localparam int SW = $clog2(NUM_W + 1);

  logic [DEN_W-1:0] rem;
  logic [DEN_W-1:0] dvs;
  logic [NUM_W-1:0] q;
  logic [SW-1:0]    step;
  logic [DEN_W:0]   rem_sh;
  logic             ge;
  logic [DEN_W-1:0] rem_nx;

  always_comb begin
    rem_sh = {rem, q[NUM_W-1]};
    ge     = rem_sh >= {1'b0, dvs};
    rem_nx = ge ? DEN_W'(rem_sh - {1'b0, dvs}) : DEN_W'(rem_sh);
  end

  always_ff @(posedge clk) begin
    if (!rst_n || clear) begin
      rem  <= '0;
      dvs  <= '0;
      q    <= '0;
      step <= '0;
      busy <= 1'b0;
      done <= 1'b0;
    end else if (start) begin
      rem  <= '0;
      dvs  <= den;
      q    <= num;
      step <= SW'(NUM_W);
      busy <= 1'b1;
      done <= 1'b0;
    end else if (busy) begin
      rem  <= rem_nx;
      q    <= {q[NUM_W-2:0], ge};
      step <= step - SW'(1);
      if (step == SW'(1)) begin
        busy <= 1'b0;
        done <= 1'b1;
      end
    end else begin
      done <= 1'b0;
    end
  end

  assign quo = q;

  a_r5_rem_below_divisor: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> rem < dvs);

endmodule

// File: rtl/tcal_histogram.sv
`timescale 1ns/1ps
module tcal_histogram #(
  parameter int FINE_W = 5,
  parameter int CNT_W  = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              hit_en,
  input  logic [FINE_W-1:0] hit_code,
  input  logic [FINE_W-1:0] rd_idx,
  output logic [CNT_W-1:0]  rd_count,
  output logic [CNT_W-1:0]  total
);
  localparam int BINS = 1 << FINE_W;

  logic [CNT_W-1:0] cnt_arr [BINS];

  for (genvar g = 0; g < BINS; g++) begin : g_bin
    logic [CNT_W-1:0] c;
    always_ff @(posedge clk) begin
      if (!rst_n || clear)
        c <= '0;
      else if (hit_en && hit_code == FINE_W'(g) && c != '1)
        c <= c + CNT_W'(1);
    end
    assign cnt_arr[g] = c;

    a_r4_bin_saturates: assert property (@(posedge clk) disable iff (!rst_n)
      (!clear && hit_en && hit_code == FINE_W'(g) && c == '1) |=> c == '1);
  end

  always_ff @(posedge clk) begin
    if (!rst_n || clear)
      total <= '0;
    else if (hit_en && total != '1)
      total <= total + CNT_W'(1);
  end

  assign rd_count = cnt_arr[rd_idx];

endmodule

// File: rtl/tcal_table.sv
`timescale 1ns/1ps
module tcal_table
  import tcal_pkg::*;
#(
  parameter int FINE_W    = 5,
  parameter int TIME_W    = 13,
  parameter int PERIOD_PS = 5000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              wr_en,
  input  logic [FINE_W-1:0] wr_idx,
  input  logic [TIME_W-1:0] wr_width,
  input  logic              look_en,
  input  logic [FINE_W-1:0] look_code,
  input  logic              use_cal,
  input  logic              look_susp,
  output logic              q_valid,
  output logic [TIME_W-1:0] q_time,
  output logic              q_susp
);
  localparam int BINS = 1 << FINE_W;

  logic [TIME_W-1:0] acc;
  logic [TIME_W-1:0] mid;
  logic [TIME_W-1:0] tarr [BINS];

  assign mid = TIME_W'(mid_time(32'(acc), 32'(wr_width)));

  always_ff @(posedge clk) begin
    if (!rst_n || clear)
      acc <= '0;
    else if (wr_en)
      acc <= acc + wr_width;
  end

  for (genvar g = 0; g < BINS; g++) begin : g_slot
    logic [TIME_W-1:0] t;
    always_ff @(posedge clk) begin
      if (!rst_n)
        t <= '0;
      else if (wr_en && wr_idx == FINE_W'(g))
        t <= mid;
    end
    assign tarr[g] = t;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      q_valid <= 1'b0;
      q_time  <= '0;
      q_susp  <= 1'b0;
    end else begin
      q_valid <= look_en;
      q_susp  <= look_en && look_susp;
      if (look_en)
        q_time <= use_cal ? tarr[look_code]
                          : TIME_W'(lin_time(32'(look_code), PERIOD_PS, FINE_W));
    end
  end

  a_r6_times_ordered: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !clear && wr_idx != '0) |=>
      tarr[$past(wr_idx)] >= tarr[$past(wr_idx) - FINE_W'(1)]);

endmodule

// File: rtl/tdc_bin_calibrator.sv
`timescale 1ns/1ps
module tdc_bin_calibrator
  import tcal_pkg::*;
#(
  parameter int FINE_W    = 5,
  parameter int CNT_W     = 12,
  parameter int PERIOD_PS = 5000,
  parameter int TIME_W    = $clog2(PERIOD_PS + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cal_mode,
  input  logic [CNT_W-1:0]  total_hits,
  input  logic              raw_valid,
  input  logic [FINE_W-1:0] raw_code,
  output logic              cal_valid,
  output logic [TIME_W-1:0] cal_time,
  output logic              cal_suspect,
  output logic              table_done
);
  localparam int BINS  = 1 << FINE_W;
  localparam int NUM_W = CNT_W + TIME_W;

  tcal_state_e       state;
  logic [FINE_W-1:0] idx;
  logic [CNT_W-1:0]  n_tgt;
  logic              mode_q;
  logic              pend;

  // Named internal events
  logic              mode_rise;
  logic              mode_fall;
  logic              hit_en;
  logic              look_en;
  logic              div_start;
  logic              div_busy;
  logic              div_done;
  logic              wr_en;
  logic [CNT_W-1:0]  bin_count;
  logic [CNT_W-1:0]  hit_total;
  logic [NUM_W-1:0]  div_quo;
  logic [NUM_W-1:0]  div_num;

  assign mode_rise = cal_mode && !mode_q;
  assign mode_fall = !cal_mode && mode_q;
  assign hit_en    = (state == ST_HIST) && cal_mode && raw_valid && (hit_total != n_tgt);
  assign look_en   = raw_valid && !cal_mode;
  assign div_start = (state == ST_LOAD);
  assign wr_en     = (state == ST_WAIT) && div_done;
  assign div_num   = NUM_W'(bin_count) * NUM_W'(PERIOD_PS);

  tcal_histogram #(.FINE_W(FINE_W), .CNT_W(CNT_W)) u_hist (
    .clk      (clk),
    .rst_n    (rst_n),
    .clear    (mode_rise),
    .hit_en   (hit_en),
    .hit_code (raw_code),
    .rd_idx   (idx),
    .rd_count (bin_count),
    .total    (hit_total)
  );

  tcal_divider #(.NUM_W(NUM_W), .DEN_W(CNT_W)) u_div (
    .clk   (clk),
    .rst_n (rst_n),
    .clear (mode_rise),
    .start (div_start),
    .num   (div_num),
    .den   (n_tgt),
    .busy  (div_busy),
    .done  (div_done),
    .quo   (div_quo)
  );

  tcal_table #(.FINE_W(FINE_W), .TIME_W(TIME_W), .PERIOD_PS(PERIOD_PS)) u_tab (
    .clk       (clk),
    .rst_n     (rst_n),
    .clear     (mode_rise),
    .wr_en     (wr_en),
    .wr_idx    (idx),
    .wr_width  (TIME_W'(div_quo)),
    .look_en   (look_en),
    .look_code (raw_code),
    .use_cal   (table_done),
    .look_susp (pend || mode_fall),
    .q_valid   (cal_valid),
    .q_time    (cal_time),
    .q_susp    (cal_suspect)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state      <= ST_IDLE;
      idx        <= '0;
      n_tgt      <= CNT_W'(1);
      mode_q     <= 1'b0;
      pend       <= 1'b0;
      table_done <= 1'b0;
    end else begin
      mode_q <= cal_mode;
      if (mode_rise) begin
        state      <= ST_HIST;
        idx        <= '0;
        n_tgt      <= (total_hits == '0) ? CNT_W'(1) : total_hits;
        table_done <= 1'b0;
        pend       <= 1'b0;
      end else begin
        pend <= (pend || mode_fall) && !look_en;
        case (state)
          ST_HIST: if (hit_total == n_tgt) state <= ST_LOAD;
          ST_LOAD: state <= ST_WAIT;
          ST_WAIT: if (div_done) begin
            if (idx == FINE_W'(BINS - 1)) begin
              state      <= ST_DONE;
              table_done <= 1'b1;
            end else begin
              idx   <= idx + FINE_W'(1);
              state <= ST_LOAD;
            end
          end
          default: state <= state;
        endcase
      end
    end
  end

  a_r3_silent_in_hist: assert property (@(posedge clk) disable iff (!rst_n)
    cal_valid |-> !$past(cal_mode));

  a_r7_done_cleared: assert property (@(posedge clk) disable iff (!rst_n)
    mode_rise |=> !table_done);

  a_r9_susp_with_valid: assert property (@(posedge clk) disable iff (!rst_n)
    cal_suspect |-> cal_valid);

  a_r4_total_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_HIST) |-> hit_total <= n_tgt);

  a_r10_target_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
    (state != ST_IDLE) |-> n_tgt != '0);

  a_r5_width_in_period: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> div_quo <= NUM_W'(PERIOD_PS));

  a_r5_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
    div_start |-> !div_busy);

endmodule

// File: tb/test_tdc_bin_calibrator.sv
`timescale 1ns/1ps
module test_tdc_bin_calibrator;
  localparam int FINE_W = 5;
  localparam int CNT_W  = 12;
  localparam int P      = 5000;
  localparam int TIME_W = 13;
  localparam int BINS   = 1 << FINE_W;
  localparam int BOUND  = BINS * (CNT_W + TIME_W + 3) + 10;

  logic              clk = 1'b0;
  logic              rst_n;
  logic              cal_mode;
  logic [CNT_W-1:0]  total_hits;
  logic              raw_valid;
  logic [FINE_W-1:0] raw_code;
  logic              cal_valid;
  logic [TIME_W-1:0] cal_time;
  logic              cal_suspect;
  logic              table_done;

  always #2.5 clk = ~clk;

  tdc_bin_calibrator #(.FINE_W(FINE_W), .CNT_W(CNT_W), .PERIOD_PS(P)) i_tdc_bin_calibrator (
    .clk(clk), .rst_n(rst_n), .cal_mode(cal_mode), .total_hits(total_hits),
    .raw_valid(raw_valid), .raw_code(raw_code), .cal_valid(cal_valid),
    .cal_time(cal_time), .cal_suspect(cal_suspect), .table_done(table_done)
  );

  int n_checks = 0;
  int n_fail   = 0;
  bit chk_on   = 0;

  // Behavioural reference state
  int m_cnt [BINS];
  int m_tbl [BINS];
  int m_total, m_N;
  bit m_prev, m_pend, m_done, m_hist;
  bit exp_valid, exp_susp;
  int exp_time;
  int unsigned seed = 32'hACE1;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    bit rise, fall, look;
    if (!rst_n) begin
      foreach (m_cnt[i]) m_cnt[i] = 0;
      m_total = 0; m_N = 1; m_prev = 0; m_pend = 0; m_done = 0; m_hist = 0;
      exp_valid = 0; exp_susp = 0; exp_time = 0;
    end else begin
      rise = cal_mode && !m_prev;
      fall = !cal_mode && m_prev;
      look = raw_valid && !cal_mode;
      if (rise) begin
        foreach (m_cnt[i]) m_cnt[i] = 0;
        m_total = 0;
        m_N = (total_hits == 0) ? 1 : int'(total_hits);
        m_done = 0; m_pend = 0; m_hist = 1;
      end else if (cal_mode && m_hist && raw_valid && m_total < m_N) begin
        m_cnt[raw_code]++;
        m_total++;
      end
      exp_valid = look;
      exp_susp  = look && (m_pend || fall);
      if (!rise) m_pend = (m_pend || fall) && !look;
      if (look) exp_time = m_done ? m_tbl[raw_code] : (int'(raw_code) * P) >> FINE_W;
      m_prev = cal_mode;
    end
  end

  always @(negedge clk) begin
    if (rst_n && chk_on) begin
      check(cal_valid == exp_valid, exp_valid ? (m_done ? "R8" : "R2") : "R3",
            cal_valid, exp_valid);
      if (exp_valid) begin
        check(int'(cal_time) == exp_time, m_done ? "R8" : "R2", cal_time, exp_time);
        check(cal_suspect == exp_susp, "R9", cal_suspect, exp_susp);
      end
      if (m_total < m_N && m_hist)
        check(table_done == 1'b0, "R7", table_done, 0);
    end
  end

  task automatic hit(input int code);
    raw_valid = 1'b1;
    raw_code  = FINE_W'(code);
    @(negedge clk);
    raw_valid = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wait_done();
    int cyc = 0;
    int acc = 0;
    while (!table_done && cyc < BOUND) begin
      @(negedge clk);
      cyc++;
    end
    check(table_done == 1'b1 && cyc < BOUND, "R7", cyc, BOUND);
    for (int i = 0; i < BINS; i++) begin
      int w;
      w = (m_cnt[i] * P) / m_N;
      m_tbl[i] = acc + w / 2;
      acc += w;
    end
    m_done = 1;
  endtask

  task automatic sweep();
    for (int c = 0; c < BINS; c++) begin
      hit(c);
      check(int'(cal_time) == m_tbl[c], "R6", cal_time, m_tbl[c]);
    end
  endtask

  initial begin
    rst_n = 1'b0; cal_mode = 1'b0; raw_valid = 1'b0; raw_code = '0; total_hits = '0;
    idle(3);
    check(!cal_valid && !cal_suspect && !table_done, "R1",
          {cal_valid, cal_suspect, table_done}, 0);
    rst_n = 1'b1;
    chk_on = 1;
    idle(1);
    check(!cal_valid && !cal_suspect && !table_done, "R1",
          {cal_valid, cal_suspect, table_done}, 0);

    // Linear fallback before any table exists
    hit(0); hit(5); idle(1);
    hit(17);
    check(int'(cal_time) == 2656, "R2", cal_time, 2656);
    hit(31); hit(1);

    // Pass 1: N = 200, skewed codes, extra hits past N
    total_hits = 200; cal_mode = 1'b1; idle(2);
    for (int i = 0; i < 212; i++) begin
      int c;
      seed = seed * 1103515245 + 12345;
      c = ((seed >> 16) % 7 == 0) ? 3 : int'((seed >> 16) % BINS);
      hit(i >= 200 ? 9 : c);
      if (i % 5 == 4) idle(1);
    end
    wait_done();
    cal_mode = 1'b0;
    hit(12);
    check(cal_suspect == 1'b1, "R9", cal_suspect, 1);
    hit(12);
    check(cal_suspect == 1'b0, "R9", cal_suspect, 0);
    sweep();

    // Pass 2: N = 0 is taken as 1
    total_hits = 0; cal_mode = 1'b1; idle(1);
    check(table_done == 1'b0, "R7", table_done, 0);
    idle(1);
    hit(7); hit(9);
    wait_done();
    cal_mode = 1'b0;
    hit(7); check(int'(cal_time) == 2500, "R10", cal_time, 2500);
    hit(6); check(int'(cal_time) == 0,    "R5",  cal_time, 0);
    hit(9); check(int'(cal_time) == 5000, "R4",  cal_time, 5000);

    // Pass 3: abandoned mid-way, then restarted
    total_hits = 37; cal_mode = 1'b1; idle(2);
    for (int i = 0; i < 10; i++) hit(2);
    cal_mode = 1'b0;
    hit(4);
    check(int'(cal_time) == 625 && cal_suspect, "R9", cal_time, 625);
    hit(4);
    cal_mode = 1'b1; idle(2);
    for (int i = 0; i < 37; i++) hit(20 + i % 4);
    wait_done();
    cal_mode = 1'b0;
    idle(1);
    hit(2);  check(int'(cal_time) == 0,   "R4", cal_time, 0);
    hit(20); check(int'(cal_time) == 675, "R5", cal_time, 675);
    sweep();

    idle(3);
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog actual=%0d expected=%0d", 200000, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

endmodule